// File: doc/BRIEF.md
# Hierarchical Memory Tag Controller

This block sits between a requester that moves whole cache lines and a plain memory that has no room for extra bits. It makes that memory behave as if every capability-sized word had one extra tag bit. The tag bits are kept in a table placed in the memory itself, directly above the data region. The table has two levels. Each leaf-table line holds the tag bits of a run of data lines. Each root bit says whether its leaf-table line holds any set bit.

A small direct-mapped, write-back cache inside the block holds recently used table lines. Every request looks up the root bit first. A clear root bit answers the tag lookup at once, without touching the leaf table. A line read returns the data and the tags of the line's words. A line write stores the data and then rewrites the leaf bits and the root bit. A tags-only query returns the tags of one line and never touches the data region.

The block handles one request at a time. Both ports use a valid/ready handshake.

Top module: `tagmem_ctrl`

## Requirements
- R1: After reset, and at any time no request is in progress, reqReady is 1, respValid is 0 and memReqValid is 0.
- R2: A read (reqOp 0, and reqOp 3 behaves the same) returns in respData the line stored at memory address reqLine. It returns in respTags the line's tags, where bit w is the tag of word w as last written. The response stays valid and unchanged until respReady is seen.
- R3: A write (reqOp 1) stores reqData at address reqLine and makes reqTags the tags of exactly that line. Tags of every other line are unchanged. A write never reads the data region.
- R4: A query (reqOp 2) returns the line's tags and never addresses the data region. The table lines it fetched stay cached, so the same query repeated with no request in between makes no memory request.
- R5: When the root bit covering a line is clear, the leaf-table line is not read, and the line's tags are reported as zero.
- R6: A root bit is 1 exactly when at least one tag bit in its leaf-table line is 1. It is set by a write with nonzero tags, kept while any bit of the block remains set, and cleared by the write that clears the block's last set bit.
- R7: Table lines are cached direct-mapped, indexed by the low bits of their memory address, with write-back. A dirty line that is displaced is written to memory before the replacing line is fetched.
- R8: Only one request is in progress at a time, and reqReady stays 0 until its response handshake. memReqValid, memAddr and memWe stay unchanged until memReqReady. Read data is taken when memRespValid is high.
- R9: Let P = (WORD_W*WORDS)/WORDS be the number of data lines per leaf-table line. Leaf-table line k sits at address 2^DATA_AW + k. Bit (n mod P)*WORDS + w of that line holds the tag of word w of data line n, where k = n / P. Root bit k mod (WORD_W*WORDS) sits in the root line at address 2^DATA_AW + (number of leaf lines) + k / (WORD_W*WORDS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and accepting a request |
| reqOp | input | 2 | 0 read, 1 write, 2 tag query, 3 read |
| reqLine | input | DATA_AW | Data line index |
| reqData | input | WORD_W*WORDS | Line data for a write |
| reqTags | input | WORDS | Per-word tags for a write |
| respValid | output | 1 | Response present |
| respReady | input | 1 | Requester takes the response |
| respData | output | WORD_W*WORDS | Line data of a read |
| respTags | output | WORDS | Per-word tags of a read or query |
| memReqValid | output | 1 | Memory request present |
| memReqReady | input | 1 | Memory takes the request |
| memWe | output | 1 | 1 for a line write, 0 for a line read |
| memAddr | output | $clog2(2^DATA_AW + leaf lines + root lines) | Memory line address |
| memWdata | output | WORD_W*WORDS | Line written to memory |
| memRespValid | input | 1 | Read data present |
| memRdata | input | WORD_W*WORDS | Read data from memory |

## Verification
The bench builds the block with WORD_W 16, WORDS 4, DATA_AW 6 and CACHE_N 2. That gives 64 data lines of 64 bits, 16 data lines per leaf-table line, four leaf lines at addresses 64 to 67 and one root line at 68. With only two cache entries, the root line and the even leaf lines share entry 0. Ordinary writes therefore displace dirty table lines, so write-back order, the memory table layout and the clearing of root bits all show up in the memory contents and the request traffic. A memory model that stalls its ready signal every third cycle exercises the hold rules on the memory port.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_QUERY   = 2'd2,
    OP_ALTREAD = 2'd3
  } reqop_e;

  typedef enum logic [1:0] {
    MS_DATA   = 2'd0,
    MS_VICTIM = 2'd1,
    MS_FILL   = 2'd2
  } memsel_e;

  // control to datapath strobes
  typedef struct packed {
    logic    latchReq;
    logic    lookRoot;
    memsel_e memSel;
    logic    capData;
    logic    fillLine;
    logic    capTags;
    logic    updLeaf;
    logic    updRoot;
  } strobe_t;

endpackage

// File: rtl/tagmem_dp.sv
module tagmem_dp
  import tagmem_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int WORDS   = 4,
  parameter int DATA_AW = 6,
  parameter int CACHE_N = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  strobe_t                           stb,
  input  logic [1:0]                        reqOp,
  input  logic [DATA_AW-1:0]                reqLine,
  input  logic [WORD_W*WORDS-1:0]           reqData,
  input  logic [WORDS-1:0]                  reqTags,
  input  logic [WORD_W*WORDS-1:0]           memRdata,
  output reqop_e                            opQ,
  output logic                              tagsAny,
  output logic                              hit,
  output logic                              victimDirty,
  output logic                              rootBitNow,
  output logic [$clog2((1<<DATA_AW) + ((1<<DATA_AW)/WORD_W)
                + ((((1<<DATA_AW)/WORD_W) + WORD_W*WORDS - 1)
                   / (WORD_W*WORDS)))-1:0] memAddr,
  output logic [WORD_W*WORDS-1:0]           memWdata,
  output logic [WORD_W*WORDS-1:0]           respData,
  output logic [WORDS-1:0]                  respTags
);
  localparam int LINE_W     = WORD_W * WORDS;
  localparam int LPL        = LINE_W / WORDS;            // data lines per leaf line
  localparam int LPL_W      = $clog2(LPL);
  localparam int DATA_LINES = 1 << DATA_AW;
  localparam int LEAF_LINES = DATA_LINES / LPL;
  localparam int ROOT_LINES = (LEAF_LINES + LINE_W - 1) / LINE_W;
  localparam int MEM_AW     = $clog2(DATA_LINES + LEAF_LINES + ROOT_LINES);
  localparam int BIT_W      = $clog2(LINE_W);
  localparam int IDX_W      = $clog2(CACHE_N);
  localparam int LEAF_BASE  = DATA_LINES;
  localparam int ROOT_BASE  = DATA_LINES + LEAF_LINES;

  logic [DATA_AW-1:0] lineQ;
  logic [LINE_W-1:0]  dataQ;
  logic [WORDS-1:0]   tagsQ;
  logic               leafAnyQ;

  logic [LINE_W-1:0]  cLine  [CACHE_N];
  logic [MEM_AW-1:0]  cTag   [CACHE_N];
  logic [CACHE_N-1:0] cValid;
  logic [CACHE_N-1:0] cDirty;

  logic [DATA_AW-1:0] leafIdx;
  logic [LPL_W-1:0]   slot;
  logic [BIT_W-1:0]   rootPos;
  logic [MEM_AW-1:0]  leafAddr, rootAddr, lookAddr;
  logic [IDX_W-1:0]   idx;
  logic [LINE_W-1:0]  curLine, newLeaf, newRoot;
  logic [WORDS-1:0]   leafSlice;

  // table addressing
  assign leafIdx  = lineQ >> LPL_W;
  assign slot     = lineQ[LPL_W-1:0];
  assign rootPos  = BIT_W'(leafIdx);
  assign leafAddr = MEM_AW'(LEAF_BASE) + MEM_AW'(leafIdx);
  assign rootAddr = MEM_AW'(ROOT_BASE) + MEM_AW'(leafIdx >> BIT_W);
  assign lookAddr = stb.lookRoot ? rootAddr : leafAddr;
  assign idx      = lookAddr[IDX_W-1:0];

  // cache lookup
  assign curLine     = cLine[idx];
  assign hit         = cValid[idx] && (cTag[idx] == lookAddr);
  assign victimDirty = cValid[idx] && cDirty[idx];
  assign rootBitNow  = curLine[rootPos];
  assign leafSlice   = curLine[slot*WORDS +: WORDS];
  assign tagsAny     = |tagsQ;

  always_comb begin
    newLeaf = curLine;
    newLeaf[slot*WORDS +: WORDS] = tagsQ;
  end

  always_comb begin
    newRoot = curLine;
    newRoot[rootPos] = leafAnyQ;
  end

  // memory port data path
  always_comb begin
    case (stb.memSel)
      MS_VICTIM: begin memAddr = cTag[idx];      memWdata = curLine; end
      MS_FILL:   begin memAddr = lookAddr;       memWdata = curLine; end
      default:   begin memAddr = MEM_AW'(lineQ); memWdata = dataQ;   end
    endcase
  end

  // request and response registers
  always_ff @(posedge clk) begin
    if (rst) begin
      opQ      <= OP_READ;
      lineQ    <= '0;
      dataQ    <= '0;
      tagsQ    <= '0;
      respData <= '0;
      respTags <= '0;
    end else begin
      if (stb.latchReq) begin
        opQ      <= reqop_e'(reqOp);
        lineQ    <= reqLine;
        dataQ    <= reqData;
        tagsQ    <= reqTags;
        respData <= '0;
        respTags <= '0;
      end
      if (stb.capData) respData <= memRdata;
      if (stb.capTags) respTags <= leafSlice;
    end
  end

  // cache state bits
  always_ff @(posedge clk) begin
    if (rst) begin
      cValid   <= '0;
      cDirty   <= '0;
      leafAnyQ <= 1'b0;
    end else begin
      if (stb.fillLine) begin
        cValid[idx] <= 1'b1;
        cDirty[idx] <= 1'b0;
      end
      if (stb.updLeaf || stb.updRoot) cDirty[idx] <= 1'b1;
      if (stb.updLeaf) leafAnyQ <= |newLeaf;
    end
  end

  // cache contents
  always_ff @(posedge clk) begin
    if (stb.fillLine) begin
      cLine[idx] <= memRdata;
      cTag[idx]  <= lookAddr;
    end else if (stb.updLeaf) begin
      cLine[idx] <= newLeaf;
    end else if (stb.updRoot) begin
      cLine[idx] <= newRoot;
    end
  end

endmodule

// File: rtl/tagmem_fsm.sv
module tagmem_fsm
  import tagmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       respReady,
  input  logic       memReqReady,
  input  logic       memRespValid,
  input  reqop_e     opQ,
  input  logic       tagsAny,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       rootBitNow,
  output strobe_t    stb,
  output logic       reqReady,
  output logic       respValid,
  output logic       memReqValid,
  output logic       memWe
);
  typedef enum logic [2:0] {
    S_IDLE, S_DATA_REQ, S_DATA_WAIT, S_LOOK,
    S_VICT, S_FILL_REQ, S_FILL_WAIT, S_RESP
  } state_e;

  typedef enum logic [1:0] {PH_ROOT, PH_LEAF, PH_ROOTSET} phase_e;

  state_e stateQ, nextState;
  phase_e phaseQ, nextPhase;
  logic   isWrite;

  assign isWrite = (opQ == OP_WRITE);

  always_comb begin
    stb          = '0;
    stb.memSel   = MS_DATA;
    stb.lookRoot = (phaseQ != PH_LEAF);
    nextState    = stateQ;
    nextPhase    = phaseQ;
    reqReady     = 1'b0;
    respValid    = 1'b0;
    memReqValid  = 1'b0;
    memWe        = 1'b0;
    case (stateQ)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.latchReq = 1'b1;
          nextPhase    = PH_ROOT;
          nextState    = (reqOp == OP_QUERY) ? S_LOOK : S_DATA_REQ;
        end
      end
      S_DATA_REQ: begin
        memReqValid = 1'b1;
        memWe       = isWrite;
        if (memReqReady) nextState = isWrite ? S_LOOK : S_DATA_WAIT;
      end
      S_DATA_WAIT: begin
        if (memRespValid) begin
          stb.capData = 1'b1;
          nextState   = S_LOOK;
        end
      end
      S_LOOK: begin
        if (!hit) begin
          nextState = victimDirty ? S_VICT : S_FILL_REQ;
        end else begin
          case (phaseQ)
            PH_ROOT: begin
              if (rootBitNow || (isWrite && tagsAny)) nextPhase = PH_LEAF;
              else                                    nextState = S_RESP;
            end
            PH_LEAF: begin
              if (isWrite) begin
                stb.updLeaf = 1'b1;
                nextPhase   = PH_ROOTSET;
              end else begin
                stb.capTags = 1'b1;
                nextState   = S_RESP;
              end
            end
            default: begin
              stb.updRoot = 1'b1;
              nextState   = S_RESP;
            end
          endcase
        end
      end
      S_VICT: begin
        stb.memSel  = MS_VICTIM;
        memReqValid = 1'b1;
        memWe       = 1'b1;
        if (memReqReady) nextState = S_FILL_REQ;
      end
      S_FILL_REQ: begin
        stb.memSel  = MS_FILL;
        memReqValid = 1'b1;
        if (memReqReady) nextState = S_FILL_WAIT;
      end
      S_FILL_WAIT: begin
        if (memRespValid) begin
          stb.fillLine = 1'b1;
          nextState    = S_LOOK;
        end
      end
      default: begin
        respValid = 1'b1;
        if (respReady) nextState = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= S_IDLE;
      phaseQ <= PH_ROOT;
    end else begin
      stateQ <= nextState;
      phaseQ <= nextPhase;
    end
  end

endmodule

// File: rtl/tagmem_ctrl.sv
module tagmem_ctrl
  import tagmem_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int WORDS   = 4,
  parameter int DATA_AW = 6,
  parameter int CACHE_N = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              reqValid,
  output logic                              reqReady,
  input  logic [1:0]                        reqOp,
  input  logic [DATA_AW-1:0]                reqLine,
  input  logic [WORD_W*WORDS-1:0]           reqData,
  input  logic [WORDS-1:0]                  reqTags,
  output logic                              respValid,
  input  logic                              respReady,
  output logic [WORD_W*WORDS-1:0]           respData,
  output logic [WORDS-1:0]                  respTags,
  output logic                              memReqValid,
  input  logic                              memReqReady,
  output logic                              memWe,
  output logic [$clog2((1<<DATA_AW) + ((1<<DATA_AW)/WORD_W)
                + ((((1<<DATA_AW)/WORD_W) + WORD_W*WORDS - 1)
                   / (WORD_W*WORDS)))-1:0] memAddr,
  output logic [WORD_W*WORDS-1:0]           memWdata,
  input  logic                              memRespValid,
  input  logic [WORD_W*WORDS-1:0]           memRdata
);
  strobe_t stb;
  reqop_e  opQ;
  logic    tagsAny, hit, victimDirty, rootBitNow;

  tagmem_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .reqValid     (reqValid),
    .reqOp        (reqOp),
    .respReady    (respReady),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .opQ          (opQ),
    .tagsAny      (tagsAny),
    .hit          (hit),
    .victimDirty  (victimDirty),
    .rootBitNow   (rootBitNow),
    .stb          (stb),
    .reqReady     (reqReady),
    .respValid    (respValid),
    .memReqValid  (memReqValid),
    .memWe        (memWe)
  );

  tagmem_dp #(
    .WORD_W  (WORD_W),
    .WORDS   (WORDS),
    .DATA_AW (DATA_AW),
    .CACHE_N (CACHE_N)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .reqOp       (reqOp),
    .reqLine     (reqLine),
    .reqData     (reqData),
    .reqTags     (reqTags),
    .memRdata    (memRdata),
    .opQ         (opQ),
    .tagsAny     (tagsAny),
    .hit         (hit),
    .victimDirty (victimDirty),
    .rootBitNow  (rootBitNow),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .respData    (respData),
    .respTags    (respTags)
  );

endmodule

// File: rtl/tagmem_chk.sv
module tagmem_chk #(
  parameter int WORD_W  = 16,
  parameter int WORDS   = 4,
  parameter int DATA_AW = 6,
  parameter int MEM_AW  = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reqValid,
  input logic                    reqReady,
  input logic [1:0]              reqOp,
  input logic                    respValid,
  input logic                    respReady,
  input logic [WORD_W*WORDS-1:0] respData,
  input logic [WORDS-1:0]        respTags,
  input logic                    memReqValid,
  input logic                    memReqReady,
  input logic                    memWe,
  input logic [MEM_AW-1:0]       memAddr
);
  localparam int DATA_LINES = 1 << DATA_AW;

  logic       busyQ;
  logic [1:0] curOp;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ <= 1'b0;
      curOp <= 2'd0;
    end else if (reqValid && reqReady) begin
      busyQ <= 1'b1;
      curOp <= reqOp;
    end else if (respValid && respReady) begin
      busyQ <= 1'b0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busyQ |-> reqReady && !respValid && !memReqValid);   // R1
  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (rst)
    busyQ |-> !reqReady);   // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr) && $stable(memWe));   // R8
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
    respValid && !respReady |=> respValid && $stable(respData) && $stable(respTags));   // R2
  AST_QUERY_TABLE_ONLY: assert property (@(posedge clk) disable iff (rst)
    busyQ && curOp == 2'd2 && memReqValid |-> memAddr >= MEM_AW'(DATA_LINES));   // R4
  AST_WRITE_NO_DATA_READ: assert property (@(posedge clk) disable iff (rst)
    busyQ && curOp == 2'd1 && memReqValid && memAddr < MEM_AW'(DATA_LINES) |-> memWe);   // R3

endmodule

bind tagmem_ctrl tagmem_chk #(
  .WORD_W  (WORD_W),
  .WORDS   (WORDS),
  .DATA_AW (DATA_AW),
  .MEM_AW  ($bits(memAddr))
) u_tagmem_chk (
  .clk         (clk),
  .rst         (rst),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqOp       (reqOp),
  .respValid   (respValid),
  .respReady   (respReady),
  .respData    (respData),
  .respTags    (respTags),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memWe       (memWe),
  .memAddr     (memAddr)
);

// File: tb/tagmem_ctrl_bench.sv
module tagmem_ctrl_bench;
  localparam int WORD_W = 16, WORDS = 4, DATA_AW = 6, CACHE_N = 2;
  localparam int LINE_W = 64, MEM_AW = 7, DATA_LINES = 64;
  localparam int LEAF_BASE = 64, ROOT_ADDR = 68;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst = 1'b1;
  logic              reqValid = 1'b0, reqReady;
  logic [1:0]        reqOp = 2'd0;
  logic [DATA_AW-1:0] reqLine = '0;
  logic [LINE_W-1:0] reqData = '0;
  logic [WORDS-1:0]  reqTags = '0;
  logic              respValid, respReady = 1'b1;
  logic [LINE_W-1:0] respData;
  logic [WORDS-1:0]  respTags;
  logic              memReqValid, memReqReady = 1'b1, memWe;
  logic [MEM_AW-1:0] memAddr;
  logic [LINE_W-1:0] memWdata;
  logic              memRespValid = 1'b0;
  logic [LINE_W-1:0] memRdata = '0;

  tagmem_ctrl #(.WORD_W(WORD_W), .WORDS(WORDS), .DATA_AW(DATA_AW), .CACHE_N(CACHE_N))
  u_tagmem_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqLine(reqLine), .reqData(reqData), .reqTags(reqTags), .respValid(respValid),
    .respReady(respReady), .respData(respData), .respTags(respTags),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRespValid(memRespValid),
    .memRdata(memRdata)
  );

  int checks = 0, fails = 0;
  logic [LINE_W-1:0] mem [1 << MEM_AW];
  logic [WORDS-1:0]  refTags [DATA_LINES];
  logic [LINE_W-1:0] refData [DATA_LINES];
  int totalReqs = 0, dataReads = 0, leafReads = 0;
  logic [LINE_W-1:0] lastData;
  logic [WORDS-1:0]  lastTags;

  // memory model: two-cycle read latency, ready drops every third cycle
  int stallPat = 0;
  logic rdPend = 1'b0;
  int rdCnt = 0;
  logic [MEM_AW-1:0] rdAddr = '0;
  always @(posedge clk) begin
    memRespValid <= 1'b0;
    stallPat     <= stallPat + 1;
    memReqReady  <= (stallPat % 3) != 1;
    if (rdPend) begin
      if (rdCnt == 0) begin
        memRespValid <= 1'b1;
        memRdata     <= mem[rdAddr];
        rdPend       <= 1'b0;
      end else rdCnt <= rdCnt - 1;
    end
    if (!rst && memReqValid && memReqReady) begin
      totalReqs = totalReqs + 1;
      if (memWe) mem[memAddr] = memWdata;
      else begin
        rdPend <= 1'b1;
        rdAddr <= memAddr;
        rdCnt  <= 1;
        if (memAddr < DATA_LINES) dataReads = dataReads + 1;
        else if (memAddr < ROOT_ADDR) leafReads = leafReads + 1;
      end
    end
  end

  function automatic logic [LINE_W-1:0] initPat(int i);
    return {16'(i), 16'(i * 3 + 1), 16'(~i), 16'hC0DE};
  endfunction

  function automatic logic [LINE_W-1:0] newPat(int i, int k);
    return {16'(i), 16'hBEEF ^ 16'(k), 16'(k * 77), 16'h1234};
  endfunction

  task automatic chk(string req, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [1:0] op, int line, logic [LINE_W-1:0] d, logic [WORDS-1:0] t);
    int guard = 0;
    @(negedge clk);
    chk("R8 reqReady before request", reqReady, 1);
    reqValid = 1'b1; reqOp = op; reqLine = DATA_AW'(line); reqData = d; reqTags = t;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respValid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk("R8 response arrives", respValid, 1);
    lastData = respData;
    lastTags = respTags;
    if (op == 2'd1) begin
      refData[line] = d;
      refTags[line] = t;
    end
  endtask

  task automatic testReset();
    chk("R1 reqReady after reset", reqReady, 1);
    chk("R1 respValid after reset", respValid, 0);
    chk("R1 memReqValid after reset", memReqValid, 0);
  endtask

  task automatic testUntouchedRead();
    int l0 = leafReads;
    run(2'd0, 5, '0, '0);
    chk("R2 untouched data", lastData, initPat(5));
    chk("R5 untouched tags zero", lastTags, 0);
    chk("R5 no leaf read under clear root", leafReads - l0, 0);
  endtask

  task automatic testWriteRead();
    run(2'd1, 3, newPat(3, 1), 4'b1010);
    chk("R7 dirty leaf written back", mem[LEAF_BASE][15:12], 4'b1010);
    chk("R9 leaf bits of other lines", {mem[LEAF_BASE][63:16], mem[LEAF_BASE][11:0]}, 0);
    run(2'd0, 3, '0, '0);
    chk("R2 written data", lastData, newPat(3, 1));
    chk("R3 written tags", lastTags, 4'b1010);
    run(2'd0, 2, '0, '0);
    chk("R3 neighbour data", lastData, initPat(2));
    chk("R3 neighbour tags", lastTags, 0);
  endtask

  task automatic testQuery();
    int d0 = dataReads;
    run(2'd2, 3, '0, '0);
    chk("R4 query tags", lastTags, 4'b1010);
    chk("R4 query no data read", dataReads - d0, 0);
    chk("R6 root bit written back", mem[ROOT_ADDR][0], 1);
    chk("R9 root line other bits", mem[ROOT_ADDR][63:1], 0);
  endtask

  task automatic testQueryCached();
    int q0;
    run(2'd1, 20, newPat(20, 2), 4'b0110);
    run(2'd2, 20, '0, '0);
    q0 = totalReqs;
    run(2'd2, 20, '0, '0);
    chk("R4 repeated query no traffic", totalReqs - q0, 0);
    chk("R4 repeated query tags", lastTags, 4'b0110);
  endtask

  task automatic testRootMaintenance();
    int l0;
    run(2'd1, 4, newPat(4, 3), 4'b0001);
    run(2'd1, 3, newPat(3, 4), 4'b0000);
    run(2'd0, 4, '0, '0);
    chk("R6 root kept while block nonzero", lastTags, 4'b0001);
    run(2'd1, 4, newPat(4, 5), 4'b0000);
    l0 = leafReads;
    run(2'd0, 7, '0, '0);
    chk("R6 root cleared with last tag", leafReads - l0, 0);
    chk("R6 cleared block reads zero", lastTags, 0);
  endtask

  task automatic testZeroWrite();
    int l0 = leafReads;
    run(2'd1, 40, newPat(40, 6), 4'b0000);
    chk("R5 zero write skips leaf", leafReads - l0, 0);
    run(2'd3, 40, '0, '0);
    chk("R2 reqOp 3 reads data", lastData, newPat(40, 6));
    chk("R2 reqOp 3 tags", lastTags, 0);
  endtask

  task automatic testSweep();
    for (int k = 0; k < 12; k++) begin
      int line = (k * 23 + 9) % DATA_LINES;
      run(2'd1, line, newPat(line, k + 10), WORDS'(k * 5 + 3));
    end
    for (int n = 0; n < DATA_LINES; n++) begin
      run(2'd2, n, '0, '0);
      chk("R3 sweep tags per line", lastTags, refTags[n]);
    end
    for (int n = 0; n < DATA_LINES; n += 9) begin
      run(2'd0, n, '0, '0);
      chk("R2 sweep data", lastData, refData[n]);
      chk("R2 sweep tags", lastTags, refTags[n]);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < (1 << MEM_AW); i++) mem[i] = (i < DATA_LINES) ? initPat(i) : '0;
    for (int i = 0; i < DATA_LINES; i++) begin
      refData[i] = initPat(i);
      refTags[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testUntouchedRead();
    testWriteRead();
    testQuery();
    testQueryCached();
    testRootMaintenance();
    testZeroWrite();
    testSweep();
    finishRun();
  end

endmodule